// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block is the digital mode controller for a single-wire bus transceiver that has its own supply regulator. It chooses one of five operating modes: unpowered, fail-safe, normal, silent and sleep. From that mode it derives the enables for the regulator, the transmit path and the bus termination. It also produces an active-low reset for the local controller. The analog parts appear only as digital flags: the supply comparators, the regulator undervoltage monitor and the bus wake detector.

The enable and transmit-data pins come from an external controller, so each passes through its own two-flop synchronizer. A falling enable edge in normal mode picks the next mode from the synchronized transmit level sampled in the same cycle: silent or sleep. A reset-hold timer counts microsecond ticks taken from a clock prescaler. It keeps the reset output low, and it blocks enable-driven mode changes, for a fixed window after the regulator output becomes good.

Top module: `trx_mode_ctrl`

## Requirements
- R1: During and right after reset the mode is unpowered, and every output is low. Mode codes on `mode_o`: 0 unpowered, 1 fail-safe, 2 normal, 3 silent, 4 sleep.
- R2: In unpowered mode, `supply_up_i` high moves the block to fail-safe on the next clock, whatever level the enable pin has.
- R3: In fail-safe, a synchronized high enable moves the block to normal once the reset-hold window has ended. In silent, a high enable moves the block directly to normal.
- R4: In normal mode, a falling edge of the synchronized enable moves the block to silent if the synchronized transmit level is high, and to sleep if it is low.
- R5: In fail-safe, normal or silent, `vcc_uv_i` high forces fail-safe on the next clock and drives `rst_out_n_o` low in that same cycle.
- R6: `wake_req_i` in silent or sleep moves the block to fail-safe on the next clock, which turns the termination back on.
- R7: In sleep, `reg_en_o` and `rst_out_n_o` are low and `rxd_low_o` is high. A high enable in sleep moves the block to fail-safe.
- R8: `rst_out_n_o` stays low for HOLD_TICKS ticks after the regulator turns on or `vcc_uv_i` falls, and the count restarts at each undervoltage release. Normal mode is never entered while this window is active.
- R9: `supply_down_i` high moves the block to unpowered from any mode on the next clock. It takes priority over every other input.
- R10: `tx_en_o` is high only in normal. `term_en_o` is high only in fail-safe and normal. `reg_en_o` is high in every mode except unpowered and sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_up_i | input | 1 | Supply above the power-on threshold (synchronous flag) |
| supply_down_i | input | 1 | Supply below the power-off threshold (synchronous flag) |
| en_i | input | 1 | Enable pin, asynchronous |
| txd_i | input | 1 | Transmit data pin, asynchronous, idle high |
| vcc_uv_i | input | 1 | Regulator output undervoltage (synchronous flag) |
| wake_req_i | input | 1 | Bus wake request pulse from the wake detector |
| mode_o | output | 3 | Current mode code |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmit path enable; when low the line stays recessive |
| term_en_o | output | 1 | Bus termination enable |
| rxd_low_o | output | 1 | Forces the receive output low |
| rst_out_n_o | output | 1 | Active-low reset for the local controller |

## Verification
The assertions assume that the supply, undervoltage and wake flags are already synchronous to `clk`. They also assume that the enable and transmit pins hold each new level for at least three clocks, because shorter pulses can vanish in the synchronizers. The bench meets both assumptions: it changes inputs only on falling clock edges and holds each level for several cycles. It drives the two supply flags together only to test the priority case, and it reports expected modes only after the three-stage latency from pin to mode register.

// File: rtl/trx_mode_pkg.sv
`timescale 1ns/1ps
package trx_mode_pkg;

    typedef enum logic [2:0] {
        MODE_OFF     = 3'd0,
        MODE_SAFE    = 3'd1,
        MODE_RUN     = 3'd2,
        MODE_QUIET   = 3'd3,
        MODE_DORMANT = 3'd4
    } trx_mode_e;

    typedef struct packed {
        logic reg_en;
        logic tx_en;
        logic term_en;
        logic rxd_low;
    } mode_ctl_t;

    typedef struct packed {
        trx_mode_e mode;
        logic      en_prev;
    } fsm_state_t;

    function automatic mode_ctl_t decode_mode(trx_mode_e m);
        mode_ctl_t c;
        c.reg_en  = (m == MODE_SAFE) || (m == MODE_RUN) || (m == MODE_QUIET);
        c.tx_en   = (m == MODE_RUN);
        c.term_en = (m == MODE_SAFE) || (m == MODE_RUN);
        c.rxd_low = (m == MODE_DORMANT);
        return c;
    endfunction

endpackage

// File: rtl/trx_sync.sv
`timescale 1ns/1ps
module trx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/trx_tick_gen.sv
`timescale 1ns/1ps
module trx_tick_gen #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == LAST) cnt_d = '0;
                else               cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/trx_hold_timer.sv
`timescale 1ns/1ps
module trx_hold_timer #(
    parameter int HOLD_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic reg_on_i,
    input  logic uv_i,
    output logic hold_o
);
    localparam int W = $clog2(HOLD_TICKS + 1);
    localparam logic [W-1:0] FULL = W'(HOLD_TICKS);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!reg_on_i || uv_i) begin
            cnt_d = FULL;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= FULL;
        else        cnt_q <= cnt_d;
    end

    assign hold_o = (cnt_q != '0);
endmodule

// File: rtl/trx_mode_fsm.sv
`timescale 1ns/1ps
module trx_mode_fsm
    import trx_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      supply_up_i,
    input  logic      supply_down_i,
    input  logic      en_s_i,
    input  logic      txd_s_i,
    input  logic      uv_i,
    input  logic      wake_i,
    input  logic      hold_i,
    output trx_mode_e mode_o
);
    fsm_state_t st_d, st_q;
    logic       en_fall;

    always_comb begin
        st_d         = st_q;
        st_d.en_prev = en_s_i;
        en_fall      = st_q.en_prev & ~en_s_i;

        if (supply_down_i) begin
            st_d.mode = MODE_OFF;
        end else begin
            case (st_q.mode)
                MODE_OFF: begin
                    if (supply_up_i) st_d.mode = MODE_SAFE;
                end
                MODE_DORMANT: begin
                    if (wake_i || en_s_i) st_d.mode = MODE_SAFE;
                end
                MODE_SAFE: begin
                    if (!uv_i && !hold_i && en_s_i) st_d.mode = MODE_RUN;
                end
                MODE_RUN: begin
                    if (uv_i) begin
                        st_d.mode = MODE_SAFE;
                    end else if (!hold_i && en_fall) begin
                        st_d.mode = txd_s_i ? MODE_QUIET : MODE_DORMANT;
                    end
                end
                MODE_QUIET: begin
                    if (uv_i || wake_i) begin
                        st_d.mode = MODE_SAFE;
                    end else if (!hold_i && en_s_i) begin
                        st_d.mode = MODE_RUN;
                    end
                end
                default: st_d.mode = MODE_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= MODE_OFF;
            st_q.en_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
endmodule

// File: rtl/trx_mode_ctrl.sv
`timescale 1ns/1ps
module trx_mode_ctrl
    import trx_mode_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TICK_DIV    = 250,
    parameter int HOLD_TICKS  = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_up_i,
    input  logic       supply_down_i,
    input  logic       en_i,
    input  logic       txd_i,
    input  logic       vcc_uv_i,
    input  logic       wake_req_i,
    output logic [2:0] mode_o,
    output logic       reg_en_o,
    output logic       tx_en_o,
    output logic       term_en_o,
    output logic       rxd_low_o,
    output logic       rst_out_n_o
);
    logic      en_s, txd_s, tick, hold;
    trx_mode_e mode;
    mode_ctl_t ctl;

    trx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .d_i(en_i), .q_o(en_s)
    );

    trx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_txd_sync (
        .clk(clk), .rst_n(rst_n), .d_i(txd_i), .q_o(txd_s)
    );

    trx_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    trx_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .reg_on_i(ctl.reg_en), .uv_i(vcc_uv_i), .hold_o(hold)
    );

    trx_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .supply_up_i(supply_up_i), .supply_down_i(supply_down_i),
        .en_s_i(en_s), .txd_s_i(txd_s), .uv_i(vcc_uv_i),
        .wake_i(wake_req_i), .hold_i(hold), .mode_o(mode)
    );

    assign ctl         = decode_mode(mode);
    assign mode_o      = mode;
    assign reg_en_o    = ctl.reg_en;
    assign tx_en_o     = ctl.tx_en;
    assign term_en_o   = ctl.term_en;
    assign rxd_low_o   = ctl.rxd_low;
    assign rst_out_n_o = ctl.reg_en & ~vcc_uv_i & ~hold;
endmodule

// File: rtl/trx_mode_ctrl_checker.sv
`timescale 1ns/1ps
module trx_mode_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       supply_up_i,
    input logic       supply_down_i,
    input logic       vcc_uv_i,
    input logic       wake_req_i,
    input logic [2:0] mode_o,
    input logic       reg_en_o,
    input logic       tx_en_o,
    input logic       term_en_o,
    input logic       rxd_low_o,
    input logic       rst_out_n_o
);
    p_legal_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd4);

    p_power_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && supply_up_i && !supply_down_i) |=> mode_o == 3'd1);

    p_uv_to_safe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_uv_i && !supply_down_i && (mode_o == 3'd1 || mode_o == 3'd2 || mode_o == 3'd3))
        |=> mode_o == 3'd1);

    p_uv_reset_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_uv_i |-> !rst_out_n_o);

    p_wake_to_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req_i && !supply_down_i && (mode_o == 3'd3 || mode_o == 3'd4))
        |=> (mode_o == 3'd1 && term_en_o));

    p_sleep_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |-> (!reg_en_o && !rst_out_n_o && rxd_low_o));

    p_normal_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd2 && $past(mode_o) != 3'd2) |-> $past(rst_out_n_o));

    p_power_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        supply_down_i |=> mode_o == 3'd0);

    p_tx_only_normal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_o |-> mode_o == 3'd2);

    p_term_modes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        term_en_o |-> (mode_o == 3'd1 || mode_o == 3'd2));
endmodule

bind trx_mode_ctrl trx_mode_ctrl_checker u_chk (.*);

// File: tb/trx_mode_ctrl_test.sv
`timescale 1ns/1ps
module trx_mode_ctrl_test;
    localparam int DIV  = 4;
    localparam int HOLD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_up = 1'b0, sup_dn = 1'b0, en = 1'b0, txd = 1'b1, uv = 1'b0, wake = 1'b0;
    logic [2:0] mode;
    logic reg_en, tx_en, term_en, rxd_low, rst_out_n;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    trx_mode_ctrl #(.SYNC_STAGES(2), .TICK_DIV(DIV), .HOLD_TICKS(HOLD)) uut (
        .clk(clk), .rst_n(rst_n),
        .supply_up_i(sup_up), .supply_down_i(sup_dn),
        .en_i(en), .txd_i(txd), .vcc_uv_i(uv), .wake_req_i(wake),
        .mode_o(mode), .reg_en_o(reg_en), .tx_en_o(tx_en),
        .term_en_o(term_en), .rxd_low_o(rxd_low), .rst_out_n_o(rst_out_n)
    );

    typedef struct packed {
        logic       ok, lost, en, txd, uv, wake;
        logic [7:0] wait_n;
        logic [7:0] expv;   // {mode[2:0], reg, tx, term, rstn, rxdlow}
        logic [3:0] req;
    } vec_t;

    localparam vec_t VECS [18] = '{
        '{0,0,0,1,0,0, 8'd4,  8'b000_00000, 4'd1},  // R1 idle unpowered
        '{1,0,1,1,0,0, 8'd3,  8'b001_10100, 4'd2},  // R2 up with enable high
        '{1,0,1,1,0,0, 8'd60, 8'b010_11110, 4'd3},  // R3 normal after hold
        '{1,0,0,1,0,0, 8'd6,  8'b011_10010, 4'd4},  // R4 silent
        '{1,0,1,1,0,0, 8'd6,  8'b010_11110, 4'd3},  // R3 silent to normal
        '{1,0,0,0,0,0, 8'd6,  8'b100_00001, 4'd4},  // R4 sleep
        '{1,0,0,0,0,1, 8'd3,  8'b001_10100, 4'd6},  // R6 wake from sleep
        '{1,0,1,1,0,0, 8'd60, 8'b010_11110, 4'd8},  // R8 hold then normal
        '{1,0,1,1,1,0, 8'd3,  8'b001_10100, 4'd5},  // R5 undervoltage
        '{1,0,1,1,0,0, 8'd60, 8'b010_11110, 4'd5},  // R5 recovery
        '{1,0,0,1,0,0, 8'd6,  8'b011_10010, 4'd4},  // R4 silent again
        '{1,0,0,1,0,1, 8'd3,  8'b001_10110, 4'd6},  // R6 wake from silent
        '{1,1,0,1,0,0, 8'd3,  8'b000_00000, 4'd9},  // R9 power loss
        '{1,0,0,1,0,0, 8'd60, 8'b001_10110, 4'd2},  // R2 up with enable low
        '{1,0,1,1,0,0, 8'd6,  8'b010_11110, 4'd3},  // R3
        '{1,0,0,0,0,0, 8'd6,  8'b100_00001, 4'd7},  // R7 sleep outputs
        '{1,0,1,0,0,0, 8'd6,  8'b001_10100, 4'd7},  // R7 enable leaves sleep
        '{1,0,1,1,0,0, 8'd60, 8'b010_11110, 4'd10}  // R10 output enables
    };

    function automatic logic [7:0] outs();
        return {mode, reg_en, tx_en, term_en, rst_out_n, rxd_low};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds everything low even with busy inputs
        sup_up = 1'b1; en = 1'b1;
        step(3);
        check("R1", outs(), 8'b000_00000);
        sup_up = 1'b0; en = 1'b0;
        step(1);
        rst_n = 1'b1;
        step(1);
        check("R1", outs(), 8'b000_00000);

        for (int i = 0; i < 18; i++) begin
            sup_up = VECS[i].ok;  sup_dn = VECS[i].lost;
            en     = VECS[i].en;  txd    = VECS[i].txd;
            uv     = VECS[i].uv;  wake   = VECS[i].wake;
            step(int'(VECS[i].wait_n));
            check($sformatf("R%0d vector %0d", VECS[i].req, i), outs(), VECS[i].expv);
        end
        wake = 1'b0;

        // R9: power loss wins over power up
        sup_up = 1'b1; sup_dn = 1'b1;
        step(3);
        check("R9", outs(), 8'b000_00000);

        // R8: hold restarts on each undervoltage release
        sup_dn = 1'b0; en = 1'b1; txd = 1'b1;
        step(20);
        check("R8", outs(), 8'b001_10100);
        uv = 1'b1;
        step(2);
        check("R5", outs(), 8'b001_10100);
        uv = 1'b0;
        step(34);
        check("R8", outs(), 8'b001_10100);
        step(14);
        check("R8", outs(), 8'b010_11110);

        // R4: an enable fall outside normal changes nothing
        uv = 1'b1;
        step(2);
        uv = 1'b0; en = 1'b0;
        step(8);
        check("R4", outs(), 8'b001_10100);
        step(50);
        check("R4", outs(), 8'b001_10110);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule